// File: doc/BRIEF.md
# Prioritized Interrupt Vector Dispatcher

Three peripheral sources can raise an interrupt: a frame-blank event, a display-status event and a timer overflow. Each source sends a strobe that lasts one cycle. The block turns each strobe into a sticky request flag. When the master enable is set and at least one request is both pending and enabled, the block raises `irq_take` and presents the fixed vector of the winning source on `irq_vector`.

The CPU core accepts the interrupt by pulsing `ack` while `irq_take` is high. On that clock edge the block clears the request it granted and clears the master enable, so one acceptance services exactly one source. The master enable is set again by a one-cycle pulse on `ime_set`, which the core issues when it executes its enable-interrupts instruction.

The stack push on the core side is outside this block, and so are the peripherals themselves.

Top module: `irq_vector_dispatch`

## Requirements
- R1: Reset clears all request flags and the master enable, so `irq_take` is 0 and `irq_vector` is 0. A reset also discards any request that was pending before it.
- R2: A strobe sets its request flag on the next rising edge and leaves the other flags unchanged. Flag bit 0 is frame-blank (`frame_evt`), bit 1 is display-status (`stat_evt`) and bit 2 is timer overflow (`tmr_evt`).
- R3: `irq_take` is 1 only when the master enable is set and some flag bit n (n = 0..2) is set while `en_mask[n]` is 1. A pending flag whose mask bit is 0 is never dispatched.
- R4: When several enabled requests are pending, frame-blank wins over display-status, and display-status wins over timer overflow.
- R5: `irq_vector` is 16'h0040 for frame-blank, 16'h0048 for display-status and 16'h0050 for timer overflow, and 16'h0000 whenever `irq_take` is 0.
- R6: A pulse on `ime_set` sets the master enable on that rising edge.
- R7: `ack` while `irq_take` is 1 clears, on that edge, only the granted request flag, and it also clears the master enable.
- R8: `ack` while `irq_take` is 0 has no effect on the flags or on the master enable.
- R9: If a strobe arrives in the same cycle as an acknowledge that clears that same flag, the flag stays set.
- R10: Mask bits `en_mask[7:3]` are ignored. A mask with only those bits set produces no dispatch.
- R11: One strobe raises one request. Once that request has been acknowledged, it does not come back without a new strobe.
- R12: If `ime_set` and an acknowledge fall in the same cycle, the master enable is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_evt | input | 1 | Frame-blank event strobe |
| stat_evt | input | 1 | Display-status event strobe |
| tmr_evt | input | 1 | Timer-overflow event strobe |
| en_mask | input | 8 | Per-source enable mask (bits 2..0 used) |
| ime_set | input | 1 | Master-enable set pulse |
| ack | input | 1 | CPU acceptance of the offered interrupt |
| irq_take | output | 1 | An enabled request is being offered |
| irq_vector | output | 16 | Vector address of the offered request |

## Verification
The block's outputs respond on two different schedules:
- Strobes, `ime_set` and `ack` change state only at the next rising edge. Their effect on `irq_take` and `irq_vector` can first be seen one cycle after they are driven.
- A change of `en_mask` shows up on the outputs within the same cycle, because both outputs decode the registered state combinationally.

The bench drives every input at the falling edge and samples one time unit later. Each table row therefore holds the outputs expected from the edges already taken together with the mask being driven in that row. The `ack` in a row acts on exactly the offer that the row checks.

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch #(
  parameter int MASK_W = 8,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_evt,
  input  logic             stat_evt,
  input  logic             tmr_evt,
  input  logic [MASK_W-1:0] en_mask,
  input  logic             ime_set,
  input  logic             ack,
  output logic             irq_take,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int NSRC = 3;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] req_q, evt, armed, grant, clr;
  logic            ime_q, accept;
  logic [IDX_W-1:0] idx;

  assign evt    = {tmr_evt, stat_evt, frame_evt};
  assign armed  = req_q & en_mask[NSRC-1:0];
  assign grant  = armed & (~armed + NSRC'(1));
  assign irq_take = ime_q & (|armed);
  assign accept = ack & irq_take;
  assign clr    = accept ? grant : '0;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (armed[i]) idx = IDX_W'(i);
  end

  assign irq_vector = irq_take ? VEC_BASE + VEC_W'(VEC_STEP) * VEC_W'(idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      ime_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~clr) | evt;
      if (ime_set)     ime_q <= 1'b1;
      else if (accept) ime_q <= 1'b0;
    end
  end
endmodule

module irq_vector_dispatch_chk #(
  parameter int MASK_W = 8,
  parameter int VEC_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_evt,
  input logic              stat_evt,
  input logic              tmr_evt,
  input logic [MASK_W-1:0] en_mask,
  input logic              ime_set,
  input logic              ack,
  input logic              irq_take,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [2:0]        req_q,
  input logic              ime_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_take);
  // R2
  frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> req_q[0]);
  // R2
  tmr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> req_q[2]);
  // R4
  frame_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && req_q[0] && en_mask[0]) |-> irq_vector == VEC_W'(16'h0040));
  // R5
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_vector == VEC_W'(16'h0040) || irq_vector == VEC_W'(16'h0048)
                  || irq_vector == VEC_W'(16'h0050)));
  // R5
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |-> irq_vector == '0);
  // R6
  ime_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ime_set |=> ime_q);
  // R7
  ime_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_take && !ime_set) |=> !ime_q);
  // R8
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_take && !ime_set) |=> ime_q == $past(ime_q));
  // R9
  clash_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_take && irq_vector == VEC_W'(16'h0048) && stat_evt) |=> req_q[1]);
  // R11
  tmr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_take && irq_vector == VEC_W'(16'h0050) && !tmr_evt) |=> !req_q[2]);
endmodule

bind irq_vector_dispatch irq_vector_dispatch_chk #(.MASK_W(MASK_W), .VEC_W(VEC_W)) chk_i (.*);

// File: tb/irq_vector_dispatch_tb_top.sv
module irq_vector_dispatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_evt = 1'b0, stat_evt = 1'b0, tmr_evt = 1'b0;
  logic [7:0] en_mask = 8'h07;
  logic ime_set = 1'b0, ack = 1'b0;
  logic irq_take;
  logic [15:0] irq_vector;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .stat_evt(stat_evt),
    .tmr_evt(tmr_evt), .en_mask(en_mask), .ime_set(ime_set), .ack(ack),
    .irq_take(irq_take), .irq_vector(irq_vector)
  );

  // row: {evt[2:0] = {tmr,stat,frame}, mask[7:0], ime_set, ack, exp_take, exp_vec[15:0]}
  localparam int NROW = 16;
  localparam logic [29:0] TBL [NROW] = '{
    {3'b101, 8'h07, 1'b0, 1'b0, 1'b0, 16'h0000},  // R3 no master enable yet
    {3'b000, 8'h07, 1'b1, 1'b0, 1'b0, 16'h0000},  // R6 pulse not yet effective
    {3'b000, 8'h07, 1'b0, 1'b0, 1'b1, 16'h0040},  // R6 enabled -> frame
    {3'b000, 8'h06, 1'b0, 1'b0, 1'b1, 16'h0050},  // R3 frame masked -> timer
    {3'b000, 8'hF8, 1'b0, 1'b0, 1'b0, 16'h0000},  // R10 upper mask bits only
    {3'b000, 8'h07, 1'b0, 1'b1, 1'b1, 16'h0040},  // R4 frame over timer, ack
    {3'b000, 8'h07, 1'b1, 1'b0, 1'b0, 16'h0000},  // R7 enable dropped by ack
    {3'b010, 8'h07, 1'b0, 1'b0, 1'b1, 16'h0050},  // R7 timer kept, R2 stat pending
    {3'b010, 8'h07, 1'b0, 1'b1, 1'b1, 16'h0048},  // R4 stat over timer, ack + new stat
    {3'b000, 8'h07, 1'b1, 1'b0, 1'b0, 16'h0000},  // R7
    {3'b000, 8'h07, 1'b1, 1'b1, 1'b1, 16'h0048},  // R9 stat survived; R12 set + ack
    {3'b000, 8'h07, 1'b0, 1'b1, 1'b1, 16'h0050},  // R12 enable kept
    {3'b000, 8'h07, 1'b1, 1'b0, 1'b0, 16'h0000},  // R7
    {3'b000, 8'h07, 1'b0, 1'b1, 1'b0, 16'h0000},  // R11 timer gone; R8 stray ack
    {3'b100, 8'h07, 1'b0, 1'b0, 1'b0, 16'h0000},  // R8
    {3'b000, 8'h07, 1'b0, 1'b0, 1'b1, 16'h0050}   // R8 enable survived stray ack
  };
  localparam int RQ [NROW] = '{3, 6, 6, 3, 10, 4, 7, 7, 4, 7, 9, 12, 7, 11, 8, 8};

  task automatic check(input string req, input logic exp_take, input logic [15:0] exp_vec);
    checks++;
    if (irq_take !== exp_take) begin
      fails++;
      $display("FAIL %s irq_take actual %b expected %b", req, irq_take, exp_take);
    end
    checks++;
    if (irq_vector !== exp_vec) begin
      fails++;
      $display("FAIL %s irq_vector actual %h expected %h", req, irq_vector, exp_vec);
    end
  endtask

  task automatic drive(input logic [2:0] e, input logic [7:0] m, input logic s, input logic a);
    @(negedge clk);
    {tmr_evt, stat_evt, frame_evt} = e;
    en_mask = m;
    ime_set = s;
    ack = a;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", 1'b0, 16'h0000);

    for (int r = 0; r < NROW; r++) begin
      drive(TBL[r][29:27], TBL[r][26:19], TBL[r][18], TBL[r][17]);
      check($sformatf("R%0d", RQ[r]), TBL[r][16], TBL[r][15:0]);
    end

    // R1: reset with a pending request and the enable set
    @(negedge clk);
    {tmr_evt, stat_evt, frame_evt} = 3'b000;
    ack = 1'b0; ime_set = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(3'b000, 8'h07, 1'b1, 1'b0);
    drive(3'b000, 8'h07, 1'b0, 1'b0);
    check("R1", 1'b0, 16'h0000);

    // R10: all sources pending, only upper mask bits set
    drive(3'b111, 8'hF8, 1'b0, 1'b0);
    drive(3'b000, 8'hF8, 1'b0, 1'b0);
    check("R10", 1'b0, 16'h0000);
    // R4: all three pending -> frame-blank wins
    drive(3'b000, 8'h07, 1'b0, 1'b0);
    check("R4", 1'b1, 16'h0040);
    // R3: only display-status enabled
    drive(3'b000, 8'h02, 1'b0, 1'b0);
    check("R3", 1'b1, 16'h0048);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule